// File: doc/BRIEF.md
# Sleep and Wake Power Controller

This block decides when a touch-sensing device may power down and when it must wake. It keeps an awake state, a timed nap state and a deep state. In the timed nap state it wakes once per programmed interval and asks the sensing logic for exactly one scan. In the deep state only a GPIO interrupt brings it back. A stay-awake counter holds the device up for a programmed number of intervals after any activity. A host-owned control pin, chosen through a pin-select register, blocks sleep for as long as the host holds it low, so bus transfers are never cut short.

The timebase is a single 512 Hz tick strobe. The interval divider counts that strobe down to one of four wake periods: 512, 64, 8 or 1 Hz. The bus protocol engine pulses `bus_evt` for every transfer. The sensing logic pulses `touch_evt` on a detected touch. The GPIO logic pulses `gpio_irq` on an interrupt. Configuration is written through a three-register byte port.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the block is awake, with `sleep_req`, `scan_req` and `bg_keep` all low. Each register reads its reset parameter value, except that the deep bit (control bit 0) always reads 0, whatever `RST_CTRL` holds.
- R2: The interval select occupies control bits 4:3 and picks the interval length in ticks: 00 is 1, 01 is 8, 10 is 64 and 11 is 512.
- R3: In timed nap (enable set, deep bit clear), the block wakes on the tick that completes one interval after it fell asleep. On that wake `scan_req` is high for exactly one clock cycle.
- R4: A stay-awake value N (address 1) applies after a timed wake, or after a touch, GPIO or bus event while awake. Both reload the counter to N and restart the interval. Sleep then starts on the tick that ends interval N+1. An event that arrives while awake reloads the counter again.
- R5: The pin-select register (address 2) uses bit 7 to pick port 0 or port 1 and bits 4:0 as a one-hot pin within that port. Port p pin i is `pin_level[p*5+i]`. While the selected pin is low, sleep is never entered. Unselected pins have no effect, and a value of zero in bits 4:0 selects no pin.
- R6: With the deep bit set, the block enters deep sleep. Ticks neither wake it nor raise `scan_req`, and only `gpio_irq` wakes it.
- R7: The GPIO interrupt that wakes the block from deep sleep leaves the deep bit set. The first touch, GPIO or bus event after that wake clears the deep bit, so the next sleep is a timed nap. Only a register write sets the deep bit again.
- R8: `bg_keep` is high exactly while asleep with the bandgap bit (control bit 5) set.
- R9: The control register (address 0) holds enable at bit 7, bandgap at bit 5, the interval select at bits 4:3 and the deep bit at bit 0. Bits 6, 2 and 1 of the control register read 0. Bits 6:5 of the pin-select register read 0. Address 3 reads 0.
- R10: With enable clear, the block never sleeps.
- R11: While in timed nap, touch and bus events have no effect: the block stays asleep and the timed wake keeps its schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 stay-awake, 2 pin select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick | input | 1 | 512 Hz timebase strobe, one cycle wide |
| touch_evt | input | 1 | Touch detected strobe |
| gpio_irq | input | 1 | GPIO interrupt strobe |
| bus_evt | input | 1 | Bus read or write strobe |
| pin_level | input | 10 | Pin levels, port 1 in bits 9:5 and port 0 in bits 4:0 |
| sleep_req | output | 1 | High while asleep (nap or deep) |
| scan_req | output | 1 | One-cycle pulse on each timed wake |
| bg_keep | output | 1 | Keep the reference powered while asleep |

## Verification
The embedded properties assume single-cycle event and tick strobes. They also assume the host does not rewrite the deep bit in the same cycle that activity clears it. The stimulus pulses each strobe for exactly one clock and spaces ticks two clocks apart. It writes registers only while the block is awake and between ticks. Pin levels change only between ticks, so any veto applies to a whole interval boundary.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int unsigned REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAY = 2'd1;
    localparam logic [1:0] ADDR_PIN  = 2'd2;

    localparam int unsigned PIN_PORT_BIT = 7;

    typedef enum logic [1:0] {
        PS_AWAKE = 2'd0,
        PS_NAP   = 2'd1,
        PS_DEEP  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic       en;
        logic       bg;
        logic [1:0] sel;
        logic       deep;
    } sleep_cfg_t;

    typedef struct packed {
        logic touch;
        logic gpio;
        logic bus;
    } evt_t;

    function automatic sleep_cfg_t cfg_unpack(logic [REG_W-1:0] b);
        sleep_cfg_t c;
        c.en   = b[7];
        c.bg   = b[5];
        c.sel  = b[4:3];
        c.deep = b[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(sleep_cfg_t c);
        logic [REG_W-1:0] b;
        b      = '0;
        b[7]   = c.en;
        b[5]   = c.bg;
        b[4:3] = c.sel;
        b[0]   = c.deep;
        return b;
    endfunction

    // Last counter value of an interval: 2^(step*sel) - 1 ticks.
    function automatic int unsigned ivl_last(logic [1:0] sel, int unsigned step);
        return (32'd1 << (step * int'(sel))) - 32'd1;
    endfunction

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
    import pwr_pkg::*;
#(
    parameter int unsigned PINS     = 5,
    parameter int unsigned STAY_W   = 8,
    parameter logic [7:0]  RST_CTRL = 8'h00,
    parameter logic [7:0]  RST_STAY = 8'h00,
    parameter logic [7:0]  RST_PIN  = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              clr_deep,
    output sleep_cfg_t        cfg,
    output logic [STAY_W-1:0] stay_val,
    output logic [2*PINS-1:0] sel_mask
);

    localparam sleep_cfg_t RST_CFG_RAW = cfg_unpack(RST_CTRL);

    sleep_cfg_t        ctrl_q;
    logic [STAY_W-1:0] stay_q;
    logic              port_q;
    logic [PINS-1:0]   onehot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= RST_CFG_RAW;
            ctrl_q.deep <= 1'b0;   // deep sleep never comes back from reset
        end else if (wr_en && addr == ADDR_CTRL) begin
            ctrl_q <= cfg_unpack(wdata);
        end else if (clr_deep) begin
            ctrl_q.deep <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stay_q   <= RST_STAY[STAY_W-1:0];
            port_q   <= RST_PIN[PIN_PORT_BIT];
            onehot_q <= RST_PIN[PINS-1:0];
        end else if (wr_en) begin
            if (addr == ADDR_STAY) stay_q <= wdata[STAY_W-1:0];
            if (addr == ADDR_PIN) begin
                port_q   <= wdata[PIN_PORT_BIT];
                onehot_q <= wdata[PINS-1:0];
            end
        end
    end

    logic [REG_W-1:0] pin_rd;
    always_comb begin
        pin_rd               = '0;
        pin_rd[PIN_PORT_BIT] = port_q;
        pin_rd[PINS-1:0]     = onehot_q;
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = cfg_pack(ctrl_q);
            ADDR_STAY: rdata = REG_W'(stay_q);
            ADDR_PIN:  rdata = pin_rd;
            default:   rdata = '0;
        endcase
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign sel_mask[i]      = !port_q && onehot_q[i];
        assign sel_mask[PINS+i] =  port_q && onehot_q[i];
    end

    assign cfg      = ctrl_q;
    assign stay_val = stay_q;

    // R7: the deep bit only ever rises through a control write
    p_deep_set_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.deep) |-> $past(wr_en && addr == ADDR_CTRL && wdata[0]));

endmodule

// File: rtl/pwr_ivl_timer.sv
module pwr_ivl_timer
    import pwr_pkg::*;
#(
    parameter int unsigned STEP = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       clr,
    output logic       bound
);

    localparam int unsigned CNT_W = 3 * STEP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_c;

    assign last_c = CNT_W'(ivl_last(sel, STEP));
    // >= lets a shorter interval select take effect on the next tick
    assign bound  = tick && (cnt_q >= last_c);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= bound ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_pkg::*;
#(
    parameter int unsigned STAY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              deep,
    input  logic [STAY_W-1:0] stay_val,
    input  logic              bound,
    input  evt_t              evt,
    input  logic              pin_ok,
    output logic              ivl_clr,
    output logic              clr_deep,
    output logic              sleep_req,
    output logic              scan_req
);

    pwr_state_e        state_q, state_n;
    logic [STAY_W-1:0] stay_q, stay_n;
    logic              dwoke_q, dwoke_n;
    logic              scan_q, scan_n;
    logic              any_evt;

    assign any_evt = evt.touch || evt.gpio || evt.bus;

    always_comb begin
        state_n  = state_q;
        stay_n   = stay_q;
        dwoke_n  = dwoke_q;
        scan_n   = 1'b0;
        ivl_clr  = 1'b0;
        clr_deep = 1'b0;
        unique case (state_q)
            PS_AWAKE: begin
                if (any_evt) begin
                    stay_n  = stay_val;
                    ivl_clr = 1'b1;
                    if (dwoke_q) begin
                        clr_deep = 1'b1;
                        dwoke_n  = 1'b0;
                    end
                end else if (bound) begin
                    if (stay_q != '0) begin
                        stay_n = stay_q - 1'b1;
                    end else if (en && pin_ok) begin
                        state_n = deep ? PS_DEEP : PS_NAP;
                        dwoke_n = 1'b0;
                    end
                end
            end
            PS_NAP: begin
                if (evt.gpio) begin
                    state_n = PS_AWAKE;
                    stay_n  = stay_val;
                    ivl_clr = 1'b1;
                end else if (bound) begin
                    state_n = PS_AWAKE;
                    stay_n  = stay_val;
                    scan_n  = 1'b1;
                end
            end
            PS_DEEP: begin
                if (evt.gpio) begin
                    state_n = PS_AWAKE;
                    stay_n  = stay_val;
                    ivl_clr = 1'b1;
                    dwoke_n = 1'b1;
                end
            end
            default: state_n = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_AWAKE;
            stay_q  <= '0;
            dwoke_q <= 1'b0;
            scan_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            stay_q  <= stay_n;
            dwoke_q <= dwoke_n;
            scan_q  <= scan_n;
        end
    end

    assign sleep_req = (state_q != PS_AWAKE);
    assign scan_req  = scan_q;

    // R3: a scan request only follows a timed nap, and lasts one cycle
    p_scan_from_nap_r3: assert property (@(posedge clk) disable iff (rst)
        scan_req |-> $past(state_q == PS_NAP) && !sleep_req);
    p_scan_single_r3: assert property (@(posedge clk) disable iff (rst)
        scan_req |=> !scan_req);

    // R5 / R10: sleep begins only with enable set and the control pin released
    p_entry_permitted_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_req) |-> $past(pin_ok && en));

    // R6: only a GPIO interrupt ends deep sleep
    p_deep_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_DEEP && !evt.gpio) |=> state_q == PS_DEEP);

    // R4: an event while awake reloads the stay-awake counter
    p_stay_reload_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && state_q == PS_AWAKE && any_evt) |-> stay_q == $past(stay_val));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned PINS     = 5,
    parameter int unsigned IVL_STEP = 3,
    parameter int unsigned STAY_W   = 8,
    parameter logic [7:0]  RST_CTRL = 8'h00,
    parameter logic [7:0]  RST_STAY = 8'h00,
    parameter logic [7:0]  RST_PIN  = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tick,
    input  logic              touch_evt,
    input  logic              gpio_irq,
    input  logic              bus_evt,
    input  logic [2*PINS-1:0] pin_level,
    output logic              sleep_req,
    output logic              scan_req,
    output logic              bg_keep
);

    sleep_cfg_t        cfg;
    logic [STAY_W-1:0] stay_val;
    logic [2*PINS-1:0] sel_mask;
    logic              clr_deep;
    logic              ivl_clr;
    logic              bound;
    logic              pin_ok;
    evt_t              evt;

    assign evt.touch = touch_evt;
    assign evt.gpio  = gpio_irq;
    assign evt.bus   = bus_evt;

    // Any selected pin held low vetoes sleep
    assign pin_ok = ~|(sel_mask & ~pin_level);

    pwr_regs #(
        .PINS(PINS), .STAY_W(STAY_W),
        .RST_CTRL(RST_CTRL), .RST_STAY(RST_STAY), .RST_PIN(RST_PIN)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .clr_deep(clr_deep),
        .cfg(cfg), .stay_val(stay_val), .sel_mask(sel_mask)
    );

    pwr_ivl_timer #(.STEP(IVL_STEP)) u_timer (
        .clk(clk), .rst(rst), .tick(tick), .sel(cfg.sel),
        .clr(ivl_clr), .bound(bound)
    );

    pwr_seq #(.STAY_W(STAY_W)) u_seq (
        .clk(clk), .rst(rst), .en(cfg.en), .deep(cfg.deep),
        .stay_val(stay_val), .bound(bound), .evt(evt), .pin_ok(pin_ok),
        .ivl_clr(ivl_clr), .clr_deep(clr_deep),
        .sleep_req(sleep_req), .scan_req(scan_req)
    );

    assign bg_keep = sleep_req && cfg.bg;

endmodule

// File: tb/tb_pwr_sleep_ctrl.sv
module tb_pwr_sleep_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0, touch_evt = 1'b0, gpio_irq = 1'b0, bus_evt = 1'b0;
    logic [9:0] pin_level = 10'h3FF;
    logic       sleep_req, scan_req, bg_keep;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    pwr_sleep_ctrl #(.RST_CTRL(8'h21)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .touch_evt(touch_evt), .gpio_irq(gpio_irq), .bus_evt(bus_evt),
        .pin_level(pin_level), .sleep_req(sleep_req), .scan_req(scan_req),
        .bg_keep(bg_keep)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk); reg_addr = a; #1 d = int'(reg_rdata);
    endtask

    task automatic pulse(input logic t, input logic g, input logic b);
        @(negedge clk); touch_evt = t; gpio_irq = g; bus_evt = b;
        @(negedge clk); touch_evt = 1'b0; gpio_irq = 1'b0; bus_evt = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    // Ticks until sleep_req equals want; records whether scan_req was seen.
    task automatic tick_until(input logic want, input int limit,
                              output int n, output int scan_seen);
        n = 0; scan_seen = 0;
        do begin
            do_tick();
            n++;
            if (scan_req) scan_seen = 1;
        end while (sleep_req != want && n < limit);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int d, n, sc, div;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 sleep_req", int'(sleep_req), 0);
        check("R1 scan_req", int'(scan_req), 0);
        check("R1 bg_keep", int'(bg_keep), 0);
        rd(2'd0, d); check("R1 ctrl deep masked", d, 8'h20);
        rd(2'd1, d); check("R1 stay", d, 0);
        rd(2'd2, d); check("R1 pin", d, 0);

        // R9 layout and unused bits
        wr(2'd0, 8'h7E); rd(2'd0, d); check("R9 ctrl readback", d, 8'h38);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R9 pin readback", d, 8'h9F);
        wr(2'd1, 8'hA5); rd(2'd1, d); check("R9 stay readback", d, 8'hA5);
        rd(2'd3, d); check("R9 addr3", d, 0);
        wr(2'd2, 8'h00);

        // R10 enable clear never sleeps
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); pulse(0, 0, 1);
        repeat (20) do_tick();
        check("R10 stays awake", int'(sleep_req), 0);

        // R2 R3 R4 sweep: interval select x stay-awake count
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                div = 1 << (3 * s);
                wr(2'd1, 8'(k));
                wr(2'd0, 8'h80 | 8'(s << 3));
                pulse(0, 0, 1);
                tick_until(1'b1, 2000, n, sc);
                check($sformatf("R2 R4 sel%0d stay%0d ticks to sleep", s, k), n, (k + 1) * div);
                check("R8 bg off without bit", int'(bg_keep), 0);
                tick_until(1'b0, 2000, n, sc);
                check($sformatf("R3 sel%0d wake ticks", s), n, div);
                check("R3 scan on wake", sc, 1);
                @(negedge clk);
                check("R3 scan one cycle", int'(scan_req), 0);
                tick_until(1'b1, 2000, n, sc);
                check($sformatf("R4 sel%0d stay%0d resleep ticks", s, k), n, (k + 1) * div);
                pulse(0, 1, 0);
                check("R6 gpio wakes nap", int'(sleep_req), 0);
            end
        end

        // R4 reload by touch while awake
        wr(2'd1, 8'd3); wr(2'd0, 8'h80); pulse(0, 0, 1);
        do_tick(); do_tick();
        pulse(1, 0, 0);
        tick_until(1'b1, 100, n, sc);
        check("R4 touch reloads", n, 4);
        pulse(0, 1, 0);

        // R8 bandgap keep
        wr(2'd1, 8'd0); wr(2'd0, 8'hA0); pulse(0, 0, 1);
        do_tick();
        check("R8 asleep", int'(sleep_req), 1);
        check("R8 bg_keep asleep", int'(bg_keep), 1);
        pulse(0, 1, 0);
        check("R8 bg_keep awake", int'(bg_keep), 0);

        // R11 touch and bus ignored during nap
        wr(2'd0, 8'h88); pulse(0, 0, 1);
        tick_until(1'b1, 100, n, sc);
        check("R11 enter nap", n, 8);
        repeat (3) do_tick();
        pulse(1, 0, 1);
        check("R11 still asleep", int'(sleep_req), 1);
        tick_until(1'b0, 100, n, sc);
        check("R11 wake schedule kept", n, 5);

        // R5 control pin veto: select port 1 pin 1 = pin_level[6]
        wr(2'd0, 8'h80); wr(2'd2, 8'h82);
        pin_level[6] = 1'b0;
        pulse(0, 0, 1);
        repeat (5) do_tick();
        check("R5 vetoed", int'(sleep_req), 0);
        pin_level[6] = 1'b1; pin_level[1] = 1'b0;
        do_tick();
        check("R5 unselected pin ignored", int'(sleep_req), 1);
        pulse(0, 1, 0);
        pin_level = 10'h3FF;
        wr(2'd2, 8'h00);

        // R6 R7 deep sleep
        wr(2'd1, 8'd1); wr(2'd0, 8'h81); pulse(0, 0, 1);
        tick_until(1'b1, 100, n, sc);
        check("R6 deep entry ticks", n, 2);
        sc = 0;
        for (int i = 0; i < 10; i++) begin
            do_tick();
            if (scan_req || !sleep_req) sc = 1;
        end
        check("R6 no timer wake in deep", sc, 0);
        pulse(0, 1, 0);
        check("R6 gpio wakes deep", int'(sleep_req), 0);
        rd(2'd0, d); check("R7 waking irq keeps deep bit", d, 8'h81);
        tick_until(1'b1, 100, n, sc);
        check("R7 re-enter deep ticks", n, 2);
        repeat (3) do_tick();
        check("R7 still deep", int'(sleep_req), 1);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        rd(2'd0, d); check("R7 activity clears deep bit", d, 8'h80);
        tick_until(1'b1, 100, n, sc);
        check("R7 nap entry ticks", n, 2);
        tick_until(1'b0, 100, n, sc);
        check("R7 timed wake after clear", n, 1);
        check("R7 scan after clear", sc, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule